// File: doc/BRIEF.md
# Two-Street Traffic Light Controller

This block sequences the signals at a crossing of two streets, called A and B. A sensor on each street reports whether traffic is waiting. The controller keeps green on a street for as long as that street's sensor stays high. It then shows yellow for exactly one clock cycle and hands green to the other street. One clock cycle stands for one decision interval. There are no timers: every state lasts a whole number of cycles.

The lights depend only on the registered state, so both light outputs change only at a rising clock edge. A parameter selects the state encoding, either a two-bit binary code or a four-bit one-hot code. The lights behave the same under either encoding. With the one-hot encoding, any state pattern that does not have exactly one bit set returns to the street-A-green state on the next clock.

Top module: `traffic_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the block enters the A-green state. `light_a` shows green and `light_b` shows red after that edge, whatever the sensor values are.
- R2: In the A-green state (`light_a` green, `light_b` red), the block stays put while `sense_a` is 1, and `sense_b` has no effect there.
- R3: In the A-green state with `sense_a` at 0, the next edge moves the block to A-yellow (`light_a` yellow, `light_b` red).
- R4: A-yellow lasts exactly one cycle. The next edge always moves the block to B-green, whatever the sensor values are.
- R5: In the B-green state (`light_a` red, `light_b` green), the block stays put while `sense_b` is 1, and `sense_a` has no effect there.
- R6: In the B-green state with `sense_b` at 0, the next edge moves the block to B-yellow (`light_a` red, `light_b` yellow).
- R7: B-yellow lasts exactly one cycle. The next edge always returns the block to A-green.
- R8: The light codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. The code 2'b11 never appears, and exactly one of the two streets shows red.
- R9: With `ONE_HOT` = 0 the state is binary (A-green 00, A-yellow 01, B-green 10, B-yellow 11). With `ONE_HOT` = 1 it is one-hot (0001, 0010, 0100, 1000). The light sequence at the ports is the same for both encodings.
- R10: The light outputs change only at a rising clock edge. A sensor change between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; takes priority over the sensors |
| sense_a | input | 1 | Traffic present on street A |
| sense_b | input | 1 | Traffic present on street B |
| light_a | output | 2 | Light code for street A |
| light_b | output | 2 | Light code for street B |

## Verification
A wrong state shows at the ports after a single edge. The lights either take a colour pair that does not belong to the expected phase, or the yellow phase lasts a cycle too long or too short. A fault in the hold condition shows as soon as a sensor drops, or fails to drop, during a green phase. The bench therefore compares both lights against a phase model after every edge. It also runs a binary instance and a one-hot instance side by side, so that any point where the two encodings diverge is caught in the same cycle.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LIGHT_W = 2;
  typedef logic [LIGHT_W-1:0] light_t;

  localparam light_t LGT_GREEN  = 2'b00;
  localparam light_t LGT_YELLOW = 2'b01;
  localparam light_t LGT_RED    = 2'b10;

  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'd0,
    PH_A_WARN = 2'd1,
    PH_B_GO   = 2'd2,
    PH_B_WARN = 2'd3
  } phase_t;

  function automatic int state_width(input bit one_hot);
    return one_hot ? NUM_PHASES : PHASE_W;
  endfunction
endpackage

// File: rtl/tlc_next_state.sv
module tlc_next_state #(
  parameter bit ONE_HOT = 1'b0,
  localparam int SW = tlc_pkg::state_width(ONE_HOT)
) (
  input  logic [SW-1:0] cur,
  input  logic          sense_a,
  input  logic          sense_b,
  output logic [SW-1:0] nxt
);
  import tlc_pkg::*;

  generate
    if (ONE_HOT) begin : g_onehot
      logic legal;
      assign legal = $onehot(cur);
      always_comb begin
        if (!legal) begin
          nxt = SW'(1);
        end else begin
          nxt[0] = (cur[0] & sense_a) | cur[3];
          nxt[1] = cur[0] & ~sense_a;
          nxt[2] = cur[1] | (cur[2] & sense_b);
          nxt[3] = cur[2] & ~sense_b;
        end
      end
    end else begin : g_binary
      always_comb begin
        case (phase_t'(cur))
          PH_A_GO:   nxt = sense_a ? SW'(PH_A_GO) : SW'(PH_A_WARN);
          PH_A_WARN: nxt = SW'(PH_B_GO);
          PH_B_GO:   nxt = sense_b ? SW'(PH_B_GO) : SW'(PH_B_WARN);
          default:   nxt = SW'(PH_A_GO);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tlc_light_decode.sv
module tlc_light_decode #(
  parameter bit ONE_HOT = 1'b0,
  localparam int SW = tlc_pkg::state_width(ONE_HOT)
) (
  input  logic [SW-1:0]       cur,
  output tlc_pkg::light_t     light_a,
  output tlc_pkg::light_t     light_b
);
  import tlc_pkg::*;

  phase_t phase;

  generate
    if (ONE_HOT) begin : g_onehot
      always_comb begin
        phase = PH_A_GO;
        for (int i = 0; i < SW; i++) begin
          if (cur == SW'(1 << i)) phase = phase_t'(i);
        end
      end
    end else begin : g_binary
      assign phase = phase_t'(cur);
    end
  endgenerate

  always_comb begin
    case (phase)
      PH_A_GO:   begin light_a = LGT_GREEN;  light_b = LGT_RED;    end
      PH_A_WARN: begin light_a = LGT_YELLOW; light_b = LGT_RED;    end
      PH_B_GO:   begin light_a = LGT_RED;    light_b = LGT_GREEN;  end
      default:   begin light_a = LGT_RED;    light_b = LGT_YELLOW; end
    endcase
  end
endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg #(
  parameter int          W         = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sense_a,
  input logic          sense_b,
  input logic [1:0]    light_a,
  input logic [1:0]    light_b,
  input logic [SW-1:0] state
);
  import tlc_pkg::*;

  // R1
  reset_entry_chk: assert property (@(posedge clk)
    rst |=> (light_a == LGT_GREEN && light_b == LGT_RED));

  // R2
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == LGT_GREEN && sense_a) |=> (light_a == LGT_GREEN && light_b == LGT_RED));

  // R3
  a_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == LGT_GREEN && !sense_a) |=> (light_a == LGT_YELLOW && light_b == LGT_RED));

  // R4
  a_warn_once_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == LGT_YELLOW) |=> (light_a == LGT_RED && light_b == LGT_GREEN));

  // R5
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (light_b == LGT_GREEN && sense_b) |=> (light_b == LGT_GREEN && light_a == LGT_RED));

  // R6
  b_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (light_b == LGT_GREEN && !sense_b) |=> (light_b == LGT_YELLOW && light_a == LGT_RED));

  // R7
  b_warn_once_chk: assert property (@(posedge clk) disable iff (rst)
    (light_b == LGT_YELLOW) |=> (light_a == LGT_GREEN && light_b == LGT_RED));

  // R8
  one_red_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((light_a == LGT_RED) != (light_b == LGT_RED)));

  generate
    if (SW == NUM_PHASES) begin : g_oh
      // R9
      onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $onehot(state));
    end
  endgenerate
endmodule

bind traffic_ctrl tlc_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
  .light_a(light_a), .light_b(light_b), .state(state_q)
);

// File: rtl/traffic_ctrl.sv
module traffic_ctrl #(
  parameter bit ONE_HOT = 1'b0,
  localparam int SW = tlc_pkg::state_width(ONE_HOT)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sense_a,
  input  logic       sense_b,
  output logic [1:0] light_a,
  output logic [1:0] light_b
);
  import tlc_pkg::*;

  localparam logic [SW-1:0] START_CODE = ONE_HOT ? SW'(1) : SW'(PH_A_GO);

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;

  tlc_next_state #(.ONE_HOT(ONE_HOT)) u_next (
    .cur(state_q), .sense_a(sense_a), .sense_b(sense_b), .nxt(state_d)
  );

  tlc_state_reg #(.W(SW), .RESET_VAL(START_CODE)) u_reg (
    .clk(clk), .rst(rst), .d(state_d), .q(state_q)
  );

  tlc_light_decode #(.ONE_HOT(ONE_HOT)) u_dec (
    .cur(state_q), .light_a(light_a), .light_b(light_b)
  );
endmodule

// File: tb/tb_traffic_ctrl.sv
`timescale 1ns/1ps
module tb_traffic_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa = 1'b0;
  logic sb = 1'b0;
  logic [1:0] la, lb, la_oh, lb_oh;

  int checks = 0;
  int fails = 0;
  int phase = 0;
  bit primed = 1'b0;

  always #4 clk = ~clk;

  traffic_ctrl #(.ONE_HOT(1'b0)) dut (
    .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .light_a(la), .light_b(lb)
  );
  traffic_ctrl #(.ONE_HOT(1'b1)) dut_oh (
    .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .light_a(la_oh), .light_b(lb_oh)
  );

  function automatic int next_phase(int p, bit r, bit a, bit b);
    if (r) return 0;
    case (p)
      0: return a ? 0 : 1;
      1: return 2;
      2: return b ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] lights_of(int p);
    case (p)
      0: return {2'b00, 2'b10};
      1: return {2'b01, 2'b10};
      2: return {2'b10, 2'b00};
      default: return {2'b10, 2'b01};
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // called right after a falling edge
  task automatic apply(bit r, bit a, bit b);
    logic [3:0] snap;
    int nxt;
    string tag;
    rst = r; sa = a; sb = b;
    snap = {la, lb};
    #3;
    if (primed) check("R10", {la, lb}, snap);
    nxt = next_phase(phase, r, a, b);
    if (r) tag = "R1";
    else if (phase == 0 && nxt == 0) tag = "R2";
    else if (phase == 0) tag = "R3";
    else if (phase == 1) tag = "R4";
    else if (phase == 2 && nxt == 2) tag = "R5";
    else if (phase == 2) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    phase = nxt;
    primed = 1'b1;
    check(tag, {la, lb}, lights_of(phase));
    check("R9", {la_oh, lb_oh}, {la, lb});
    check("R8", {1'b0, (la == 2'b11), 1'b0, (lb == 2'b11)}, 4'b0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    // R1: reset with both sensors high still lands in A-green
    apply(1, 1, 1);
    apply(1, 0, 0);
    // R2: hold A green, B sensor toggling
    for (int i = 0; i < 6; i++) apply(0, 1, i[0]);
    // R3, then R4 with sensors that would otherwise hold
    apply(0, 0, 1);
    check("R8", {la, lb}, 4'b0110);
    apply(0, 1, 0);
    check("R4", {la, lb}, 4'b1000);
    // R5: hold B green with A sensor toggling
    for (int i = 0; i < 5; i++) apply(0, i[0], 1);
    // R6 then R7 with B sensor high during yellow
    apply(0, 1, 0);
    check("R8", {la, lb}, 4'b1001);
    apply(0, 0, 1);
    check("R7", {la, lb}, 4'b0010);
    // R1: reset mid-cycle from B green
    apply(0, 0, 1);
    apply(0, 0, 1);
    apply(1, 0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit r = ($urandom_range(0, 39) == 0);
      bit a = ($urandom_range(0, 3) != 0);
      bit b = ($urandom_range(0, 2) != 0);
      apply(r, a, b);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule